// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM. It takes the memory from power-on to a usable state. After a synchronous reset it keeps the clock-enable and data-mask pins high and presents only no-operation commands for a programmable power-up wait. It then closes both banks with a precharge-all command. After that come two configuration steps in an order fixed by a parameter: one mode-register load with a parameterised opcode, and a programmable burst of auto-refresh commands. Every minimum delay is a parameter in nanoseconds. Each is turned into clock cycles by dividing by the clock period and rounding up, and the gap after each command is padded with no-ops until that command's minimum has passed.

Once the sequence is over, `done` stays high, `busy` stays low and the command pins stay at no-op. A one-cycle `wake_req` pulse while `done` is high makes the block leave the idle state and issue a short run of wake-up auto-refreshes. It is meant for the case where the refresh interval has lapsed. When the run is over the block returns to the idle state. Periodic refresh, read/write scheduling and the data path belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset and throughout the power-up wait, the command pins show no-op (`{cs_n,ras_n,cas_n,we_n}` = 0111), `addr` is zero, `done` is 0 and `busy` is 1; `cke` and `dqm` are 1 at all times.
- R2: The first non-no-op command appears exactly PWR cycles after the first clock period that follows reset release, where PWR is the power-up time converted to cycles.
- R3: That first command is precharge-all: pins 0010 with address bit 10 set and every other address bit zero.
- R4: A mode-register load (pins 0000) is issued exactly once per initialization, with `addr` equal to the `MODE_OPCODE` parameter.
- R5: Auto-refresh (pins 0001, `addr` zero) is issued `INIT_REFRESHES` times during initialization; fewer than 8 is rejected at elaboration.
- R6: With `MRS_FIRST`=1 the order is precharge, mode load, refreshes; with 0 it is precharge, refreshes, mode load. The next command follows a precharge after RP cycles, a mode load after MRD cycles and a refresh after RFC cycles, with no-ops in between.
- R7: Each time parameter T is converted to cycles as ceil(T·1000 / `CLK_PS`).
- R8: `done` rises exactly the post-command gap of the last configuration command (MRD or RFC cycles) after that command. It then holds, with `busy` = not `done` and the pins at no-op.
- R9: A `wake_req` sampled high while `done` is high makes the next cycle carry an auto-refresh. Then come `WAKE_REFRESHES` refreshes spaced RFC cycles apart, with `done` low, and `done` returns RFC cycles after the last one.
- R10: `wake_req` while `busy` is high has no effect on any output.
- R11: Asserting `rst` in the middle of the sequence restarts it from the beginning of the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| wake_req | input | 1 | Request for wake-up refreshes, accepted only while `done` |
| cke | output | 1 | Clock enable to the memory, held high |
| dqm | output | 1 | Data mask to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: opcode for mode load, bit 10 for precharge-all |
| done | output | 1 | Sequence complete and idle |
| busy | output | 1 | Sequence or wake-up refreshes in progress |

## Verification
Every cycle of every run is compared against a schedule the bench derives arithmetically from the parameters. The power-up wait is chosen so that the cycle conversion must round up. A design that truncates would issue the precharge one cycle early. Two instances cover both step orders with different refresh counts, so a swapped order, a miscounted refresh loop or a gap timed from the wrong command shows up as a command in the wrong cycle. The bench holds `wake_req` high through initialization and pulses it again during the wake-up refreshes; a design that accepted it early would refresh out of schedule. A reset in the middle of the precharge gap must reproduce the full power-up wait, not resume where it stopped.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // Command pin encodings, packed as {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_PRE,
      ST_MRS,
      ST_REF,
      ST_DONE,
      ST_WAKE
   } init_st_e;

   // Minimum time in ns to whole clock cycles, rounded up
   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned clk_ps);
      return (t_ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
   parameter int unsigned N_INIT = 8,
   parameter int unsigned N_WAKE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   input  logic sel_wake,
   output logic last
);

   localparam int unsigned N_MAX = (N_INIT > N_WAKE) ? N_INIT : N_WAKE;
   localparam int unsigned RW    = $clog2(N_MAX + 1);

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] target;

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + 1'b1;
   end

   assign target = sel_wake ? RW'(N_WAKE - 1) : RW'(N_INIT - 1);
   assign last   = (cnt_q == target);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned AP_BIT = 10,
   parameter logic [ADDR_W-1:0] MODE_OPCODE = '0
) (
   input  init_st_e          st,
   input  logic              fire,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;

   sdr_cmd_e cmd;

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      if (fire) begin
         unique case (st)
            ST_PRE: begin
               cmd  = CMD_PRE;
               addr = PRE_ALL_ADDR;
            end
            ST_MRS: begin
               cmd  = CMD_MRS;
               addr = MODE_OPCODE;
            end
            ST_REF, ST_WAKE: cmd = CMD_REF;
            default: cmd = CMD_NOP;
         endcase
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter bit          MRS_FIRST = 1'b1,
   parameter int unsigned TW        = 8,
   parameter int unsigned RP_C      = 1,
   parameter int unsigned MRD_C     = 1,
   parameter int unsigned RFC_C     = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wake_req,
   input  logic          zero,
   input  logic          last,
   output init_st_e      st,
   output logic          fire,
   output logic          load,
   output logic [TW-1:0] load_val,
   output logic          rc_inc,
   output logic          rc_clr,
   output logic          sel_wake,
   output logic          done
);

   init_st_e st_q, st_d;
   init_st_e after_pre, after_mrs, after_ref;

   // Step order variant
   generate
      if (MRS_FIRST) begin : g_mode_then_refresh
         assign after_pre = ST_MRS;
         assign after_mrs = ST_REF;
         assign after_ref = ST_DONE;
      end else begin : g_refresh_then_mode
         assign after_pre = ST_REF;
         assign after_ref = ST_MRS;
         assign after_mrs = ST_DONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         st_q <= ST_PWR;
      else
         st_q <= st_d;
   end

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      rc_inc   = 1'b0;
      rc_clr   = 1'b0;
      unique case (st_q)
         ST_PWR: begin
            if (zero) st_d = ST_PRE;
         end
         ST_PRE: begin
            if (zero) begin
               st_d     = after_pre;
               load     = 1'b1;
               load_val = TW'(RP_C - 1);
            end
         end
         ST_MRS: begin
            if (zero) begin
               st_d     = after_mrs;
               load     = 1'b1;
               load_val = TW'(MRD_C - 1);
            end
         end
         ST_REF: begin
            if (zero) begin
               rc_inc   = 1'b1;
               load     = 1'b1;
               load_val = TW'(RFC_C - 1);
               if (last) begin
                  st_d   = after_ref;
                  rc_clr = 1'b1;
               end
            end
         end
         ST_WAKE: begin
            if (zero) begin
               rc_inc   = 1'b1;
               load     = 1'b1;
               load_val = TW'(RFC_C - 1);
               if (last) begin
                  st_d   = ST_DONE;
                  rc_clr = 1'b1;
               end
            end
         end
         ST_DONE: begin
            if (zero && wake_req) begin
               st_d   = ST_WAKE;
               rc_clr = 1'b1;
            end
         end
         default: st_d = ST_PWR;
      endcase
   end

   assign st       = st_q;
   assign fire     = zero && (st_q inside {ST_PRE, ST_MRS, ST_REF, ST_WAKE});
   assign sel_wake = (st_q == ST_WAKE);
   assign done     = (st_q == ST_DONE) && zero;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_PS         = 4000,
   parameter int unsigned T_POWERUP_NS   = 200000,
   parameter int unsigned T_RP_NS        = 20,
   parameter int unsigned T_RFC_NS       = 70,
   parameter int unsigned T_MRD_NS       = 10,
   parameter int unsigned INIT_REFRESHES = 8,
   parameter int unsigned WAKE_REFRESHES = 2,
   parameter bit          MRS_FIRST      = 1'b1,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned AP_BIT         = 10,
   parameter logic [ADDR_W-1:0] MODE_OPCODE = 12'h033
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wake_req,
   output logic              cke,
   output logic              dqm,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic              done,
   output logic              busy
);

   localparam int unsigned PWR_C = ns_to_cycles(T_POWERUP_NS, CLK_PS);
   localparam int unsigned RP_C  = ns_to_cycles(T_RP_NS, CLK_PS);
   localparam int unsigned RFC_C = ns_to_cycles(T_RFC_NS, CLK_PS);
   localparam int unsigned MRD_C = ns_to_cycles(T_MRD_NS, CLK_PS);
   localparam int unsigned MAX_C = max2(max2(PWR_C, RP_C), max2(RFC_C, MRD_C));
   localparam int unsigned TW    = $clog2(MAX_C + 1);

   // Elaboration-time parameter checks
   generate
      if (CLK_PS == 0) begin : g_bad_clk
         $error("sdram_init_seq: CLK_PS must be nonzero");
      end
      if (INIT_REFRESHES < 8) begin : g_bad_init_ref
         $error("sdram_init_seq: INIT_REFRESHES must be at least 8");
      end
      if (WAKE_REFRESHES < 1) begin : g_bad_wake_ref
         $error("sdram_init_seq: WAKE_REFRESHES must be at least 1");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap_bit
         $error("sdram_init_seq: AP_BIT must lie inside the address bus");
      end
      if ((PWR_C == 0) || (RP_C == 0) || (RFC_C == 0) || (MRD_C == 0)) begin : g_bad_time
         $error("sdram_init_seq: every minimum time must be nonzero");
      end
   endgenerate

   logic          zero, last, fire, load, rc_inc, rc_clr, sel_wake;
   logic [TW-1:0] load_val;
   init_st_e      st;

   sdram_init_timer #(
      .CNT_W   (TW),
      .RST_VAL (PWR_C - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .zero     (zero)
   );

   sdram_init_refcnt #(
      .N_INIT (INIT_REFRESHES),
      .N_WAKE (WAKE_REFRESHES)
   ) u_refcnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (rc_clr),
      .inc      (rc_inc),
      .sel_wake (sel_wake),
      .last     (last)
   );

   sdram_init_fsm #(
      .MRS_FIRST (MRS_FIRST),
      .TW        (TW),
      .RP_C      (RP_C),
      .MRD_C     (MRD_C),
      .RFC_C     (RFC_C)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .wake_req (wake_req),
      .zero     (zero),
      .last     (last),
      .st       (st),
      .fire     (fire),
      .load     (load),
      .load_val (load_val),
      .rc_inc   (rc_inc),
      .rc_clr   (rc_clr),
      .sel_wake (sel_wake),
      .done     (done)
   );

   sdram_init_cmd_enc #(
      .ADDR_W      (ADDR_W),
      .AP_BIT      (AP_BIT),
      .MODE_OPCODE (MODE_OPCODE)
   ) u_enc (
      .st    (st),
      .fire  (fire),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .addr  (addr)
   );

   assign cke  = 1'b1;
   assign dqm  = 1'b1;
   assign busy = ~done;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
   import sdram_init_pkg::*;
#(
   parameter int unsigned CLK_PS         = 4000,
   parameter int unsigned T_POWERUP_NS   = 200000,
   parameter int unsigned T_RP_NS        = 20,
   parameter int unsigned T_RFC_NS       = 70,
   parameter int unsigned T_MRD_NS       = 10,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned AP_BIT         = 10,
   parameter logic [ADDR_W-1:0] MODE_OPCODE = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              wake_req,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              done,
   input logic              busy
);

   localparam int unsigned PWR_C = ns_to_cycles(T_POWERUP_NS, CLK_PS);
   localparam int unsigned RP_C  = ns_to_cycles(T_RP_NS, CLK_PS);
   localparam int unsigned RFC_C = ns_to_cycles(T_RFC_NS, CLK_PS);
   localparam int unsigned MRD_C = ns_to_cycles(T_MRD_NS, CLK_PS);
   localparam int unsigned SW    = $clog2(PWR_C + 2) + 1;
   localparam int unsigned GW    = $clog2(max2(RP_C, max2(RFC_C, MRD_C)) + 2) + 1;

   logic [3:0]    cmd;
   logic          is_cmd;
   logic [SW-1:0] since_q;
   logic [GW-1:0] gap_q, need_q;
   logic          have_q;

   assign cmd    = {cs_n, ras_n, cas_n, we_n};
   assign is_cmd = (cmd != CMD_NOP);

   always_ff @(posedge clk) begin
      if (rst)
         since_q <= '0;
      else if (since_q != '1)
         since_q <= since_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         need_q <= '0;
         have_q <= 1'b0;
      end else if (is_cmd) begin
         gap_q  <= GW'(1);
         have_q <= 1'b1;
         need_q <= (cmd == CMD_PRE) ? GW'(RP_C) :
                   (cmd == CMD_MRS) ? GW'(MRD_C) : GW'(RFC_C);
      end else if (gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R1: power-up wait is all no-op with the block busy
   a_r1_wait_nop: assert property (@(posedge clk) disable iff (rst)
      (since_q < SW'(PWR_C)) |-> (cmd == CMD_NOP && busy && !done));

   // R2: precharge exactly when the wait ends
   a_r2_pre_on_time: assert property (@(posedge clk) disable iff (rst)
      (since_q == SW'(PWR_C)) |-> (cmd == CMD_PRE));

   // R3: precharge closes all banks
   a_r3_pre_all: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE) |-> (addr[AP_BIT] && $countones(addr) == 1));

   // R4: mode load carries the opcode
   a_r4_mrs_opcode: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_MRS) |-> (addr == MODE_OPCODE));

   // R6: spacing after each command honours its minimum
   a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && have_q) |-> (gap_q >= need_q));

   // R8: idle means no-op, and idle holds without a request
   a_r8_idle_nop: assert property (@(posedge clk) disable iff (rst)
      done |-> (cmd == CMD_NOP));
   a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
      (done && !wake_req) |=> done);

   // R9: accepted wake request refreshes on the next cycle
   a_r9_wake_ref: assert property (@(posedge clk) disable iff (rst)
      (done && wake_req) |=> (cmd == CMD_REF && !done));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
   .CLK_PS       (CLK_PS),
   .T_POWERUP_NS (T_POWERUP_NS),
   .T_RP_NS      (T_RP_NS),
   .T_RFC_NS     (T_RFC_NS),
   .T_MRD_NS     (T_MRD_NS),
   .ADDR_W       (ADDR_W),
   .AP_BIT       (AP_BIT),
   .MODE_OPCODE  (MODE_OPCODE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wake_req (wake_req),
   .cs_n     (cs_n),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .we_n     (we_n),
   .addr     (addr),
   .done     (done),
   .busy     (busy)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

   localparam int CLK_PS = 4000;
   localparam int T_PWR  = 401;   // 100.25 cycles: must round up to 101 (R7)
   localparam int T_RP   = 15;    // 3.75 -> 4
   localparam int T_RFC  = 60;    // 15
   localparam int T_MRD  = 8;     // 2
   localparam int N_A    = 8;
   localparam int N_B    = 9;
   localparam int N_WAKE = 2;
   localparam logic [11:0] OP_A = 12'h032;
   localparam logic [11:0] OP_B = 12'h021;

   localparam int PWR_C = (T_PWR * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int RP_C  = (T_RP  * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int RFC_C = (T_RFC * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int MRD_C = (T_MRD * 1000 + CLK_PS - 1) / CLK_PS;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_MRS = 4'b0000;
   localparam logic [3:0] C_REF = 4'b0001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wake_req = 1'b0;
   int   errors = 0;
   int   checks = 0;

   logic a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_done, a_busy;
   logic b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_done, b_busy;
   logic [11:0] a_addr, b_addr;

   always #2 clk = ~clk;

   sdram_init_seq #(
      .CLK_PS (CLK_PS), .T_POWERUP_NS (T_PWR), .T_RP_NS (T_RP),
      .T_RFC_NS (T_RFC), .T_MRD_NS (T_MRD), .INIT_REFRESHES (N_A),
      .WAKE_REFRESHES (N_WAKE), .MRS_FIRST (1'b1), .ADDR_W (12),
      .AP_BIT (10), .MODE_OPCODE (OP_A)
   ) u_dut (
      .clk (clk), .rst (rst), .wake_req (wake_req), .cke (a_cke), .dqm (a_dqm),
      .cs_n (a_cs), .ras_n (a_ras), .cas_n (a_cas), .we_n (a_we),
      .addr (a_addr), .done (a_done), .busy (a_busy)
   );

   sdram_init_seq #(
      .CLK_PS (CLK_PS), .T_POWERUP_NS (T_PWR), .T_RP_NS (T_RP),
      .T_RFC_NS (T_RFC), .T_MRD_NS (T_MRD), .INIT_REFRESHES (N_B),
      .WAKE_REFRESHES (N_WAKE), .MRS_FIRST (1'b0), .ADDR_W (12),
      .AP_BIT (10), .MODE_OPCODE (OP_B)
   ) u_dut_alt (
      .clk (clk), .rst (rst), .wake_req (wake_req), .cke (b_cke), .dqm (b_dqm),
      .cs_n (b_cs), .ras_n (b_ras), .cas_n (b_cas), .we_n (b_we),
      .addr (b_addr), .done (b_done), .busy (b_busy)
   );

   // Expected command in cycle k after reset release (R2, R6)
   function automatic logic [3:0] exp_init(input int k, input bit mf, input int n);
      int t;
      if (k < PWR_C) return C_NOP;
      if (k == PWR_C) return C_PRE;
      t = PWR_C + RP_C;
      if (mf) begin
         if (k == t) return C_MRS;
         t = t + MRD_C;
         for (int i = 0; i < n; i++) if (k == t + i * RFC_C) return C_REF;
      end else begin
         for (int i = 0; i < n; i++) if (k == t + i * RFC_C) return C_REF;
         if (k == t + n * RFC_C) return C_MRS;
      end
      return C_NOP;
   endfunction

   // Cycle in which done first rises (R8)
   function automatic int done_at(input bit mf, input int n);
      return mf ? (PWR_C + RP_C + MRD_C + n * RFC_C) : (PWR_C + RP_C + n * RFC_C + MRD_C);
   endfunction

   function automatic string tag_for(input int k, input logic [3:0] e, input bit ed);
      if (e == C_PRE) return "R2 R3 R7";
      if (e == C_MRS) return "R4 R6";
      if (e == C_REF) return "R5 R6";
      if (k < PWR_C)  return "R1";
      if (ed)         return "R8";
      return "R6";
   endfunction

   task automatic check_dut(input int d, input int k, input logic [3:0] ecmd,
                            input bit edone, input string tag);
      logic [3:0]  acmd;
      logic [11:0] aaddr, eaddr;
      logic        acke, adqm, adone, abusy;
      if (d == 0) begin
         acmd = {a_cs, a_ras, a_cas, a_we}; aaddr = a_addr;
         acke = a_cke; adqm = a_dqm; adone = a_done; abusy = a_busy;
      end else begin
         acmd = {b_cs, b_ras, b_cas, b_we}; aaddr = b_addr;
         acke = b_cke; adqm = b_dqm; adone = b_done; abusy = b_busy;
      end
      eaddr = (ecmd == C_PRE) ? 12'h400 :
              (ecmd == C_MRS) ? ((d == 0) ? OP_A : OP_B) : 12'h000;
      checks++;
      if (acmd !== ecmd || aaddr !== eaddr || acke !== 1'b1 || adqm !== 1'b1 ||
          adone !== edone || abusy !== !edone) begin
         errors++;
         $display("FAIL %s dut%0d cycle %0d: cmd=%b addr=%h cke=%b dqm=%b done=%b busy=%b expected cmd=%b addr=%h cke=1 dqm=1 done=%b busy=%b",
                  tag, d, k, acmd, aaddr, acke, adqm, adone, abusy, ecmd, eaddr, edone, !edone);
      end
   endtask

   // Called right after reset is released; checks every cycle of both instances
   task automatic sweep_init(input int len, input bit hold_wake, input string extra);
      int dmin;
      dmin = (done_at(1'b1, N_A) < done_at(1'b0, N_B)) ? done_at(1'b1, N_A) : done_at(1'b0, N_B);
      for (int k = 0; k < len; k++) begin
         wake_req = hold_wake && (k < dmin - 1);   // R10: request while busy
         #1;
         for (int d = 0; d < 2; d++) begin
            bit          mf;
            int          n;
            logic [3:0]  e;
            bit          ed;
            mf = (d == 0);
            n  = (d == 0) ? N_A : N_B;
            e  = exp_init(k, mf, n);
            ed = (k >= done_at(mf, n));
            check_dut(d, k, e, ed, $sformatf("%s%s", tag_for(k, e, ed), extra));
         end
         @(negedge clk);
      end
      wake_req = 1'b0;
   endtask

   // Wake-up refresh run; a second request during the run must be ignored (R9, R10)
   task automatic sweep_wake(input int len);
      for (int j = 0; j < len; j++) begin
         wake_req = (j == 0) || (j == 5);
         #1;
         for (int d = 0; d < 2; d++) begin
            logic [3:0] e;
            bit         ed;
            e  = (j == 1 || j == 1 + RFC_C) ? C_REF : C_NOP;
            ed = (j == 0) || (j >= 1 + N_WAKE * RFC_C);
            check_dut(d, j, e, ed, (j == 5) ? "R9 R10" : "R9");
         end
         @(negedge clk);
      end
      wake_req = 1'b0;
   endtask

   task automatic pulse_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int len;
      len = ((done_at(1'b1, N_A) > done_at(1'b0, N_B)) ? done_at(1'b1, N_A) : done_at(1'b0, N_B)) + 8;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // Full initialization, wake_req held high while busy (R1-R8 checks, R10)
      sweep_init(len, 1'b1, " R10");
      // Wake-up refreshes from the idle state (R9)
      sweep_wake(N_WAKE * RFC_C + 10);
      // Reset in the middle of the precharge gap, then a full rerun (R11)
      pulse_reset();
      sweep_init(PWR_C + RP_C - 1, 1'b0, "");
      pulse_reset();
      sweep_init(len, 1'b0, " R11");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired: done never settled, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule